// File: doc/BRIEF.md
# Pipeline Trap Commit Unit

This block owns the exception and interrupt path of a classic five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Every instruction carries three things down the pipeline: a pending-trap flag, a cause code and its own address. A stage that detects a fault only marks the instruction it holds. It takes no action at that point. All action is deferred to the memory stage, which is the single commit point.

At the commit point the unit arbitrates among causes. An external interrupt request wins over any fault. Among faults, the one recorded by the earliest stage wins. When a trap is taken, the unit loads the cause and exception-PC registers, kills the younger instructions in fetch, decode and execute, blocks the trapping instruction from writeback and from memory, and steers fetch to a fixed handler address.

The interrupt line is asynchronous. It passes through a two-flop synchroniser. Each rising edge of the synchronised line is held as a request until an instruction occupies the commit point and the trap is taken.

Top module: `trap_commit`

## Requirements
- R1: After reset the cause register reads 0, the exception PC reads 0, and redirectValid, wbValid and memCommit are all low.
- R2: A fault seen in fetch, decode or execute raises no redirect while its instruction is still younger than the memory stage. The redirect appears in the cycle that the instruction sits in the memory stage.
- R3: For one instruction, the earliest stage's fault decides the cause. The cause codes are: 2 for an instruction-address fault in fetch, 3 for an illegal opcode in decode, 4 for arithmetic overflow in execute, and 5 for a data-address fault in memory.
- R4: A pending interrupt request overrides any fault on the instruction at the commit point and records cause 1.
- R5: On a taken trap, the cause register and the exception PC update at the next clock edge. The exception PC takes the address of the instruction that was at the commit point. With no trap, both registers hold their values.
- R6: While a trap is taken, redirectValid and all four kill outputs are high together, and redirectPc equals the HandlerPc parameter.
- R7: An instruction killed by a trap never reaches writeback and never raises a trap later, even if a fault was flagged for it.
- R8: An interrupt pulse is synchronised through two flops, so a trap can occur at the second clock edge after the pulse. The request is held while the commit point is empty and is cleared once taken.
- R9: memCommit is high for a valid, non-trapping instruction at the commit point, and low whenever that instruction traps.
- R10: A valid instruction with no fault reaches writeback one cycle after the commit point, with wbValid high and wbPc equal to its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | An instruction enters fetch this cycle |
| fetchPc | input | PcW | Address of the fetched instruction |
| fetchPcFault | input | 1 | Instruction-address fault for the fetched instruction |
| decIllegal | input | 1 | Illegal opcode for the instruction in decode |
| exeOverflow | input | 1 | Arithmetic overflow for the instruction in execute |
| memAddrFault | input | 1 | Data-address fault for the instruction in memory |
| irqAsync | input | 1 | Asynchronous external interrupt request |
| killFetch | output | 1 | Drop the instruction in fetch |
| killDecode | output | 1 | Drop the instruction in decode |
| killExecute | output | 1 | Drop the instruction in execute |
| killWriteback | output | 1 | Block the committing instruction from writeback |
| redirectValid | output | 1 | Steer fetch to redirectPc |
| redirectPc | output | PcW | Trap handler address |
| causeOut | output | 3 | Cause register |
| epcOut | output | PcW | Exception PC register |
| memCommit | output | 1 | Instruction at the commit point may access memory |
| wbValid | output | 1 | Writeback-stage instruction may write the register file |
| wbPc | output | PcW | Address of the writeback-stage instruction |

## Verification
A wrong pending flag or cause code in the pipeline registers stays hidden until the instruction reaches the memory stage. It then shows within three cycles of the fault, as a redirect in the wrong cycle or a wrong cause value one edge later. A failure to flush shows as a spurious wbValid or a second redirect within three cycles of the trap. A synchroniser or hold fault shows as an interrupt trap arriving one cycle early or late, as an interrupt lost while the pipeline is empty, or as one interrupt taken twice.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CauseW = 3;

  typedef enum logic [CauseW-1:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_IRQ     = 3'd1,
    CAUSE_PCFAULT = 3'd2,
    CAUSE_ILLEGAL = 3'd3,
    CAUSE_OVF     = 3'd4,
    CAUSE_DADDR   = 3'd5
  } causeCode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       take;
    causeCode_t cause;
  } trapStrobe_t;

  // datapath -> control: state of the commit-point instruction
  typedef struct packed {
    logic       valid;
    logic       exc;
    causeCode_t cause;
  } commitStat_t;
endpackage

// File: rtl/trap_datapath.sv
module trap_datapath
  import trap_pkg::*;
#(
  parameter int PcW = 32,
  parameter logic [PcW-1:0] HandlerPc = '0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           fetchValid,
  input  logic [PcW-1:0] fetchPc,
  input  logic           fetchPcFault,
  input  logic           decIllegal,
  input  logic           exeOverflow,
  input  trapStrobe_t    strobe,
  output commitStat_t    mStat,
  output logic [PcW-1:0] redirectPc,
  output logic [CauseW-1:0] causeReg,
  output logic [PcW-1:0] epcReg,
  output logic           memCommit,
  output logic           wbValid,
  output logic [PcW-1:0] wbPc
);
  logic dValid, eValid, mValid;
  logic dExc, eExc, mExc;
  causeCode_t dCause, eCause, mCause;
  logic [PcW-1:0] dPc, ePc, mPc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dValid <= 1'b0; eValid <= 1'b0; mValid <= 1'b0; wbValid <= 1'b0;
      dExc <= 1'b0; eExc <= 1'b0; mExc <= 1'b0;
      dCause <= CAUSE_NONE; eCause <= CAUSE_NONE; mCause <= CAUSE_NONE;
      dPc <= '0; ePc <= '0; mPc <= '0; wbPc <= '0;
      causeReg <= '0; epcReg <= '0;
    end else begin
      // fetch -> decode
      dValid <= fetchValid & ~strobe.take;
      dExc   <= fetchValid & fetchPcFault;
      dCause <= CAUSE_PCFAULT;
      dPc    <= fetchPc;
      // decode -> execute, older flag wins
      eValid <= dValid & ~strobe.take;
      eExc   <= dValid & (dExc | decIllegal);
      eCause <= dExc ? dCause : CAUSE_ILLEGAL;
      ePc    <= dPc;
      // execute -> memory
      mValid <= eValid & ~strobe.take;
      mExc   <= eValid & (eExc | exeOverflow);
      mCause <= eExc ? eCause : CAUSE_OVF;
      mPc    <= ePc;
      // memory -> writeback
      wbValid <= mValid & ~strobe.take;
      wbPc    <= mPc;
      if (strobe.take) begin
        causeReg <= strobe.cause;
        epcReg   <= mPc;
      end
    end
  end

  assign mStat      = '{valid: mValid, exc: mExc, cause: mCause};
  assign memCommit  = mValid & ~strobe.take;
  assign redirectPc = HandlerPc;

  // R5
  cause_epc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> (causeReg == $past(strobe.cause)) && (epcReg == $past(mPc)));
  // R5
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> $stable(causeReg) && $stable(epcReg));
  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> !dValid && !eValid && !mValid && !wbValid);
  // R9
  take_needs_instr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> mValid && !memCommit);
endmodule

// File: rtl/trap_control.sv
module trap_control
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        irqAsync,
  input  logic        memAddrFault,
  input  commitStat_t mStat,
  output trapStrobe_t strobe
);
  logic irqS1, irqS2, irqS3, irqHeld;
  logic irqRise, irqReq, faultHere;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqS1 <= 1'b0; irqS2 <= 1'b0; irqS3 <= 1'b0; irqHeld <= 1'b0;
    end else begin
      irqS1   <= irqAsync;
      irqS2   <= irqS1;
      irqS3   <= irqS2;
      irqHeld <= irqReq & ~strobe.take;
    end
  end

  assign irqRise   = irqS2 & ~irqS3;
  assign irqReq    = irqHeld | irqRise;
  assign faultHere = mStat.exc | memAddrFault;

  always_comb begin
    strobe.take  = mStat.valid & (irqReq | faultHere);
    strobe.cause = CAUSE_NONE;
    if (irqReq)          strobe.cause = CAUSE_IRQ;
    else if (mStat.exc)  strobe.cause = mStat.cause;
    else if (memAddrFault) strobe.cause = CAUSE_DADDR;
  end

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqHeld && !mStat.valid) |=> irqHeld);
  // R4
  irq_override_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqHeld && mStat.valid) |-> strobe.take && (strobe.cause == CAUSE_IRQ));
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && strobe.cause == CAUSE_IRQ) |=> !irqHeld);
endmodule

// File: rtl/trap_commit.sv
module trap_commit
  import trap_pkg::*;
#(
  parameter int PcW = 32,
  parameter logic [PcW-1:0] HandlerPc = 32'h0000_0080
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           fetchValid,
  input  logic [PcW-1:0] fetchPc,
  input  logic           fetchPcFault,
  input  logic           decIllegal,
  input  logic           exeOverflow,
  input  logic           memAddrFault,
  input  logic           irqAsync,
  output logic           killFetch,
  output logic           killDecode,
  output logic           killExecute,
  output logic           killWriteback,
  output logic           redirectValid,
  output logic [PcW-1:0] redirectPc,
  output logic [2:0]     causeOut,
  output logic [PcW-1:0] epcOut,
  output logic           memCommit,
  output logic           wbValid,
  output logic [PcW-1:0] wbPc
);
  trapStrobe_t strobe;
  commitStat_t mStat;

  trap_control u_ctrl (
    .clk(clk), .rstN(rstN), .irqAsync(irqAsync), .memAddrFault(memAddrFault),
    .mStat(mStat), .strobe(strobe)
  );

  trap_datapath #(.PcW(PcW), .HandlerPc(HandlerPc)) u_dp (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .fetchPcFault(fetchPcFault), .decIllegal(decIllegal), .exeOverflow(exeOverflow),
    .strobe(strobe), .mStat(mStat), .redirectPc(redirectPc), .causeReg(causeOut),
    .epcReg(epcOut), .memCommit(memCommit), .wbValid(wbValid), .wbPc(wbPc)
  );

  assign redirectValid = strobe.take;
  assign killFetch     = strobe.take;
  assign killDecode    = strobe.take;
  assign killExecute   = strobe.take;
  assign killWriteback = strobe.take;
endmodule

// File: tb/trap_commit_tb.sv
module trap_commit_tb;
  localparam logic [31:0] HANDLER = 32'h0000_0080;
  // {fetchFault, decodeFault, executeFault, memoryFault, expected cause}
  localparam int NV = 9;
  localparam logic [6:0] VEC [NV] = '{
    {4'b0000, 3'd0}, {4'b1000, 3'd2}, {4'b0100, 3'd3}, {4'b0010, 3'd4},
    {4'b0001, 3'd5}, {4'b0110, 3'd3}, {4'b1001, 3'd2}, {4'b0011, 3'd4},
    {4'b1111, 3'd2}
  };

  logic clk = 0, rstN = 0;
  logic fetchValid = 0, fetchPcFault = 0, decIllegal = 0, exeOverflow = 0;
  logic memAddrFault = 0, irqAsync = 0;
  logic [31:0] fetchPc = '0;
  logic killFetch, killDecode, killExecute, killWriteback, redirectValid;
  logic [31:0] redirectPc, epcOut, wbPc;
  logic [2:0] causeOut;
  logic memCommit, wbValid;
  int errors = 0, checks = 0;
  logic [2:0] lastCause = 3'd0;
  logic [31:0] lastEpc = '0;

  always #10 clk = ~clk;

  trap_commit #(.PcW(32), .HandlerPc(HANDLER)) u_dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .fetchPcFault(fetchPcFault), .decIllegal(decIllegal), .exeOverflow(exeOverflow),
    .memAddrFault(memAddrFault), .irqAsync(irqAsync), .killFetch(killFetch),
    .killDecode(killDecode), .killExecute(killExecute), .killWriteback(killWriteback),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .causeOut(causeOut),
    .epcOut(epcOut), .memCommit(memCommit), .wbValid(wbValid), .wbPc(wbPc)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic nextCycle();
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    nextCycle(); nextCycle();
    // R1 reset state
    eq("R1 cause", {29'd0, causeOut}, 0);
    eq("R1 epc", epcOut, 0);
    eq("R1 redirect", {31'd0, redirectValid}, 0);
    eq("R1 wbValid", {31'd0, wbValid}, 0);
    eq("R1 memCommit", {31'd0, memCommit}, 0);
    rstN = 1;
    nextCycle();

    // table walk: one instruction per vector
    for (int i = 0; i < NV; i++) begin
      logic [31:0] pc;
      logic any;
      pc = 32'h1000 + 32'(i) * 4;
      any = |VEC[i][6:3];
      fetchValid = 1; fetchPc = pc; fetchPcFault = VEC[i][6];
      #1 eq("R2 no early redirect F", {31'd0, redirectValid}, 0);
      nextCycle();
      fetchValid = 0; fetchPcFault = 0; decIllegal = VEC[i][5];
      #1 eq("R2 no early redirect D", {31'd0, redirectValid}, 0);
      nextCycle();
      decIllegal = 0; exeOverflow = VEC[i][4];
      #1 eq("R2 no early redirect E", {31'd0, redirectValid}, 0);
      nextCycle();
      exeOverflow = 0; memAddrFault = VEC[i][3];
      #1 eq("R2 redirect at commit", {31'd0, redirectValid}, {31'd0, any});
      eq("R9 memCommit", {31'd0, memCommit}, {31'd0, !any});
      if (any) begin
        eq("R6 redirectPc", redirectPc, HANDLER);
        eq("R6 kills", {28'd0, killFetch, killDecode, killExecute, killWriteback}, 32'hF);
      end
      nextCycle();
      memAddrFault = 0;
      #1;
      if (any) begin lastCause = VEC[i][2:0]; lastEpc = pc; end
      eq("R3 cause", {29'd0, causeOut}, {29'd0, lastCause});
      eq("R5 epc", epcOut, lastEpc);
      eq("R10 wbValid", {31'd0, wbValid}, {31'd0, !any});
      if (!any) eq("R10 wbPc", wbPc, pc);
    end

    // R7: younger instructions flushed by a trap stay silent
    nextCycle();
    fetchValid = 1; fetchPc = 32'h2000; nextCycle();
    fetchPc = 32'h2004; nextCycle();
    fetchPc = 32'h2008; nextCycle();
    fetchPc = 32'h200C; memAddrFault = 1; exeOverflow = 1; decIllegal = 1;
    #1 eq("R7 trap taken", {31'd0, redirectValid}, 1);
    nextCycle();
    fetchValid = 0; memAddrFault = 0; exeOverflow = 0; decIllegal = 0;
    for (int k = 0; k < 4; k++) begin
      #1;
      eq("R7 no redirect after flush", {31'd0, redirectValid}, 0);
      eq("R7 no writeback after flush", {31'd0, wbValid}, 0);
      nextCycle();
    end
    eq("R7 cause", {29'd0, causeOut}, 5);
    eq("R7 epc", epcOut, 32'h2000);

    // R8: interrupt pulse while pipeline empty is held
    irqAsync = 1; nextCycle();
    irqAsync = 0;
    for (int k = 0; k < 3; k++) begin
      #1 eq("R8 waits for instruction", {31'd0, redirectValid}, 0);
      nextCycle();
    end
    // R4: interrupt overrides overflow on that instruction
    fetchValid = 1; fetchPc = 32'h3000; nextCycle();
    fetchValid = 0; nextCycle();
    exeOverflow = 1; nextCycle();
    exeOverflow = 0;
    #1 eq("R4 redirect", {31'd0, redirectValid}, 1);
    nextCycle();
    #1 eq("R4 cause irq", {29'd0, causeOut}, 1);
    eq("R4 epc", epcOut, 32'h3000);
    // R8: request cleared after being taken
    fetchValid = 1; fetchPc = 32'h3004; nextCycle();
    fetchValid = 0; nextCycle(); nextCycle();
    #1 eq("R8 cleared", {31'd0, redirectValid}, 0);
    nextCycle();
    #1 eq("R10 wb after irq", wbPc, 32'h3004);
    eq("R10 wbValid after irq", {31'd0, wbValid}, 1);

    // R8 latency with a full pipeline
    for (int k = 0; k < 6; k++) begin
      nextCycle();
      fetchValid = 1; fetchPc = 32'h4000 + 32'(k) * 4;
      irqAsync = (k == 3);
      #1;
      if (k == 4) eq("R8 not yet after one edge", {31'd0, redirectValid}, 0);
      if (k == 5) eq("R8 taken after two edges", {31'd0, redirectValid}, 1);
    end
    nextCycle();
    fetchValid = 0;
    #1 eq("R8 epc", epcOut, 32'h4008);
    eq("R8 cause", {29'd0, causeOut}, 1);
    for (int k = 0; k < 4; k++) begin
      nextCycle();
      #1 eq("R8 single take", {31'd0, redirectValid}, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule